// File: doc/BRIEF.md
# Indexed Codec Register Interface

This block is the host-side register front end of an audio codec. A byte-wide bus reaches four direct ports, selected by a 2-bit port number. Port 0 holds an index pointer. Port 1 reads and writes the indirect register that the pointer selects. Port 2 reports and clears the interrupt. Port 3 is a programmed-I/O data port, which reads as zero and ignores writes. Behind the pointer sits a file of 32 byte registers. In the base mode, only the lower 16 of them can be reached.

Each indirect register has its own access rule. The playback format register accepts writes only while one of two change-enable bits is set. The block gives the downstream audio path a one-cycle strobe together with the accepted format byte, a playback-enable level and a mode flag. A playback-done input sets the interrupt. Two separate write paths clear it again. A one-shot calibration indication appears when the mode-change-enable bit rises while calibration is requested.

Top module: `codec_regif`

## Requirements
- R1: After reset, the pointer port reads 0x40. Indirect registers 2, 3, 4, 5, 18 and 19 read 0x88. Registers 6 and 7 read 0x80. Register 9 reads 0x08. Register 12 reads 0x8A. Registers 25 and 26 read 0xA0. All other registers read 0x00. The status port reads 0x00 and the irq output is low.
- R2: Bit 7 of the pointer is never stored, and pointer reads return it as 0. Bit 6 of the pointer is the mode-change-enable (MCE) bit.
- R3: When bit 6 of register 12 (mode2) is clear, the indirect index is pointer bits [3:0]. When that bit is set, the index is pointer bits [4:0]. The mode2 output follows that bit.
- R4: A data write to register 8 is stored in full when MCE is 1. If MCE is 0 and bit 4 of register 24 is 1, only bits [7:4] are taken and bits [3:0] keep their stored value. If both bits are 0, the write is dropped.
- R5: Each accepted write to register 8 raises fmt_load for exactly one cycle, starting in the cycle after the write. While fmt_load is high, fmt_byte holds the stored value. A dropped write gives no strobe.
- R6: Writes to registers 22, 27 and 29 are ignored, and these registers read 0. Register 11 cannot be written. Bit 5 of register 9 is always stored as 0. The play_en output equals bit 0 of register 9.
- R7: A write to register 12 changes only bit 6. The other bits of register 12 stay at 0x8A.
- R8: Any write to the status port clears INT (status bit 0), drops irq, and clears bits 4, 5 and 6 of register 24.
- R9: A pulse on play_irq_set sets INT and bit 4 of register 24, and raises irq in the next cycle. If a set and a clear arrive in the same cycle, the set wins.
- R10: A data write to register 24 that takes bit 4 from 1 to 0 clears INT and drops irq. A write that leaves bit 4 at 1 does not.
- R11: If MCE goes from 0 to 1 while bit 3 or bit 4 of register 9 is set, a counter is loaded with CAL_LOAD. While the counter is nonzero, reads of register 11 return bit 5 set, and each such read decrements the counter. If both configuration bits are clear, the MCE rise has no effect.
- R12: The PIO data port reads 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 2 | Direct port: 0 pointer, 1 data, 2 status, 3 PIO |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe (drives read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port (combinational) |
| play_irq_set | input | 1 | Playback-done event, sets the interrupt |
| fmt_load | output | 1 | One-cycle strobe after an accepted format write |
| fmt_byte | output | 8 | Current format register value |
| play_en | output | 1 | Playback-enable level |
| irq | output | 1 | Interrupt request |
| mode2 | output | 1 | Extended-index mode flag |

## Verification
The calibration indication is the hardest behaviour to reach from the ports. It needs three things in order: a configuration byte with a calibration bit set, a pointer write with MCE clear, and then a pointer write with MCE set. The reset pointer already has MCE set, so the stimulus first drains any pending count. It then makes a clean 0-to-1 edge, and checks exactly one flagged read followed by a clear one. It also repeats the edge with the configuration bits cleared, where no flag may appear. The partial-change path needs mode2 to be on first, because register 24 can only be reached through the wide index. Interrupt races are covered by pulsing the set input in the same cycle as a status-port write.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;
   typedef enum logic [1:0] {
      PORT_PTR    = 2'd0,
      PORT_DATA   = 2'd1,
      PORT_STATUS = 2'd2,
      PORT_PIO    = 2'd3
   } port_e;

   localparam int unsigned IX_FMT   = 8;
   localparam int unsigned IX_CFG   = 9;
   localparam int unsigned IX_CAL   = 11;
   localparam int unsigned IX_MODE  = 12;
   localparam int unsigned IX_FEAT  = 24;
   localparam int unsigned MODE_BIT = 6;
   localparam int unsigned PCHG_BIT = 4;
   localparam logic [7:0]  MODE_FIXED = 8'h8A;

   function automatic logic [7:0] reset_value(input int unsigned i);
      case (i)
         2, 3, 4, 5, 18, 19: reset_value = 8'h88;
         6, 7:               reset_value = 8'h80;
         9:                  reset_value = 8'h08;
         12:                 reset_value = MODE_FIXED;
         25, 26:             reset_value = 8'hA0;
         default:            reset_value = 8'h00;
      endcase
   endfunction

   function automatic logic is_reserved(input int unsigned i);
      is_reserved = (i == 22) || (i == 27) || (i == 29);
   endfunction
endpackage

// File: rtl/cri_pointer.sv
module cri_pointer #(
   parameter int unsigned IDX_W    = 5,
   parameter int unsigned CAL_LOAD = 1,
   localparam int unsigned CAL_W   = $clog2(CAL_LOAD + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ptr_wr,
   input  logic [6:0]       ptr_wdata,
   input  logic             cal_rd,
   input  logic             cal_arm,
   input  logic             mode2,
   output logic [6:0]       ptr_q,
   output logic [IDX_W-1:0] reg_idx,
   output logic             mce,
   output logic             cal_flag
);
   logic [CAL_W-1:0] cal_cnt;

   assign mce      = ptr_q[6];
   assign cal_flag = (cal_cnt != '0);
   assign reg_idx  = mode2 ? ptr_q[IDX_W-1:0] : {1'b0, ptr_q[IDX_W-2:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= 7'h40;
         cal_cnt <= '0;
      end else begin
         if (ptr_wr) ptr_q <= ptr_wdata;
         if (ptr_wr && !ptr_q[6] && ptr_wdata[6] && cal_arm)
            cal_cnt <= CAL_W'(CAL_LOAD);
         else if (cal_rd && cal_flag)
            cal_cnt <= cal_cnt - 1'b1;
      end
   end

   // R11: the countdown never exceeds its load value
   a_r11_cal_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cal_cnt <= CAL_W'(CAL_LOAD));
   // R11: a flagged read consumes one count
   a_r11_cal_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_rd && cal_flag && !ptr_wr) |=> (cal_cnt == $past(cal_cnt) - 1'b1));
endmodule

// File: rtl/cri_intr.sv
module cri_intr (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic status_wr,
   input  logic pchg_fall,
   output logic int_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      int_q <= 1'b0;
      else if (set_ev)                 int_q <= 1'b1;
      else if (status_wr || pchg_fall) int_q <= 1'b0;
   end

   // R9: set event raises the flag, winning over clears
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev |=> int_q);
   // R8 / R10: either clear path drops the flag
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_wr || pchg_fall) && !set_ev) |=> !int_q);
endmodule

// File: rtl/cri_file.sv
module cri_file
   import codec_regif_pkg::*;
#(
   parameter int unsigned IDX_W = 5,
   localparam int unsigned NREGS = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_wr,
   input  logic [IDX_W-1:0] addr,
   input  logic [7:0]       wdata,
   input  logic             mce,
   input  logic             set_ev,
   input  logic             status_wr,
   output logic [7:0]       regs_q [NREGS],
   output logic             pchg_fall,
   output logic             fmt_load,
   output logic             fmt_accept
);
   logic pchg;

   assign pchg       = regs_q[IX_FEAT][PCHG_BIT];
   assign fmt_accept = data_wr && (addr == IDX_W'(IX_FMT)) && (mce || pchg);
   assign pchg_fall  = data_wr && (addr == IDX_W'(IX_FEAT)) && pchg && !wdata[PCHG_BIT];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      logic hit;
      assign hit = data_wr && (addr == IDX_W'(i));
      if (is_reserved(i) || i == IX_CAL) begin : g_ro
         assign regs_q[i] = reset_value(i);
      end else if (i == IX_FMT) begin : g_fmt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          regs_q[i] <= reset_value(i);
            else if (fmt_accept) regs_q[i] <= mce ? wdata : {wdata[7:4], regs_q[i][3:0]};
         end
      end else if (i == IX_CFG) begin : g_cfg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   regs_q[i] <= reset_value(i);
            else if (hit) regs_q[i] <= wdata & 8'hDF;
         end
      end else if (i == IX_MODE) begin : g_mode
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   regs_q[i] <= reset_value(i);
            else if (hit) regs_q[i] <= MODE_FIXED | {1'b0, wdata[MODE_BIT], 6'b0};
         end
      end else if (i == IX_FEAT) begin : g_feat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[i] <= reset_value(i);
            else begin
               logic [7:0] nxt;
               nxt = hit ? wdata : regs_q[i];
               if (status_wr) nxt = nxt & 8'h8F;
               if (set_ev)    nxt[PCHG_BIT] = 1'b1;
               regs_q[i] <= nxt;
            end
         end
      end else begin : g_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   regs_q[i] <= reset_value(i);
            else if (hit) regs_q[i] <= wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fmt_load <= 1'b0;
      else        fmt_load <= fmt_accept;
   end

   // R4: with neither change-enable bit the format byte holds
   a_r4_fmt_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && addr == IDX_W'(IX_FMT) && !mce && !pchg) |=> $stable(regs_q[IX_FMT]));
   // R4: partial change keeps the low nibble
   a_r4_fmt_nibble: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && addr == IDX_W'(IX_FMT) && !mce && pchg)
      |=> (regs_q[IX_FMT][3:0] == $past(regs_q[IX_FMT][3:0])));
   // R8: status write clears feature bits 4..6 unless re-set
   a_r8_feat_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (status_wr && !set_ev) |=> (regs_q[IX_FEAT][6:4] == 3'b000));
endmodule

// File: rtl/codec_regif.sv
module codec_regif
   import codec_regif_pkg::*;
#(
   parameter int unsigned IDX_W    = 5,
   parameter int unsigned CAL_LOAD = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] bus_sel,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       play_irq_set,
   output logic       fmt_load,
   output logic [7:0] fmt_byte,
   output logic       play_en,
   output logic       irq,
   output logic       mode2
);
   localparam int unsigned NREGS = 1 << IDX_W;

   if (IDX_W != 5) begin : g_bad_idx
      $error("codec_regif: IDX_W must be 5");
   end
   if (CAL_LOAD < 1) begin : g_bad_cal
      $error("codec_regif: CAL_LOAD must be at least 1");
   end

   logic [7:0]       regs_q [NREGS];
   logic [6:0]       ptr_q;
   logic [IDX_W-1:0] reg_idx;
   logic             mce, cal_flag, int_q, pchg_fall, fmt_accept;
   logic             ptr_wr, data_wr, status_wr, cal_rd, cal_arm;

   assign ptr_wr    = bus_wr && (bus_sel == PORT_PTR);
   assign data_wr   = bus_wr && (bus_sel == PORT_DATA);
   assign status_wr = bus_wr && (bus_sel == PORT_STATUS);
   assign cal_rd    = bus_rd && (bus_sel == PORT_DATA) && (reg_idx == IDX_W'(IX_CAL));
   assign mode2     = regs_q[IX_MODE][MODE_BIT];
   assign cal_arm   = |regs_q[IX_CFG][4:3];

   cri_pointer #(.IDX_W(IDX_W), .CAL_LOAD(CAL_LOAD)) u_ptr (
      .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(bus_wdata[6:0]),
      .cal_rd(cal_rd), .cal_arm(cal_arm), .mode2(mode2),
      .ptr_q(ptr_q), .reg_idx(reg_idx), .mce(mce), .cal_flag(cal_flag));

   cri_file #(.IDX_W(IDX_W)) u_file (
      .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .addr(reg_idx),
      .wdata(bus_wdata), .mce(mce), .set_ev(play_irq_set), .status_wr(status_wr),
      .regs_q(regs_q), .pchg_fall(pchg_fall), .fmt_load(fmt_load),
      .fmt_accept(fmt_accept));

   cri_intr u_intr (
      .clk(clk), .rst_n(rst_n), .set_ev(play_irq_set), .status_wr(status_wr),
      .pchg_fall(pchg_fall), .int_q(int_q));

   assign irq      = int_q;
   assign fmt_byte = regs_q[IX_FMT];
   assign play_en  = regs_q[IX_CFG][0];

   always_comb begin
      unique case (bus_sel)
         PORT_PTR:    bus_rdata = {1'b0, ptr_q};
         PORT_DATA:   bus_rdata = regs_q[reg_idx] |
                                  ((reg_idx == IDX_W'(IX_CAL) && cal_flag) ? 8'h20 : 8'h00);
         PORT_STATUS: bus_rdata = {7'b0, int_q};
         default:     bus_rdata = 8'h00;
      endcase
   end

   // R2: pointer reads never show bit 7
   a_r2_ptr_b7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel == PORT_PTR) |-> !bus_rdata[7]);
   // R5: the strobe follows an accepted format write by one cycle
   a_r5_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_accept |=> fmt_load);
   // R5: the strobe is a single cycle unless another write is accepted
   a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_load && !fmt_accept) |=> !fmt_load);
   // R7: fixed bits of the mode register never move
   a_r7_mode_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr && reg_idx == IDX_W'(IX_MODE) |=> ((regs_q[IX_MODE] & 8'hBF) == MODE_FIXED));
endmodule

// File: tb/test_codec_regif.sv
`timescale 1ns/1ps
module test_codec_regif;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_sel = 2'd0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       play_irq_set = 1'b0;
   logic       fmt_load, play_en, irq, mode2;
   logic [7:0] fmt_byte;
   int         n_checks = 0, n_errs = 0;
   logic       done = 1'b0;

   always #10 clk = ~clk;

   codec_regif i_codec_regif (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .play_irq_set(play_irq_set),
      .fmt_load(fmt_load), .fmt_byte(fmt_byte), .play_en(play_en), .irq(irq),
      .mode2(mode2));

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] p, input logic [7:0] v);
      @(negedge clk);
      bus_sel = p; bus_wdata = v; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] p, output logic [7:0] v);
      @(negedge clk);
      bus_sel = p; bus_rd = 1'b1;
      #2 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rdi(input logic [7:0] ptr, output logic [7:0] v);
      wr(2'd0, ptr);
      rd(2'd1, v);
   endtask

   task automatic t_reset;
      logic [7:0] v;
      check("R1 irq", int'(irq), 0);
      rd(2'd0, v);        check("R1 pointer", v, 8'h40);
      rd(2'd2, v);        check("R1 status", v, 8'h00);
      rdi(8'h42, v);      check("R1 reg2", v, 8'h88);
      rdi(8'h47, v);      check("R1 reg7", v, 8'h80);
      rdi(8'h49, v);      check("R1 reg9", v, 8'h08);
      rdi(8'h4C, v);      check("R1 reg12", v, 8'h8A);
      rdi(8'h40, v);      check("R1 reg0", v, 8'h00);
   endtask

   task automatic t_pointer_mode;
      logic [7:0] v;
      wr(2'd0, 8'hC3);
      rd(2'd0, v);        check("R2 bit7 dropped", v, 8'h43);
      wr(2'd0, 8'h4C); wr(2'd1, 8'h40);
      check("R3 mode2 on", int'(mode2), 1);
      rdi(8'h59, v);      check("R1 reg25", v, 8'hA0);
      rdi(8'h52, v);      check("R1 reg18", v, 8'h88);
      rdi(8'h4C, v);      check("R7 mode keep", v, 8'hCA);
      wr(2'd1, 8'hFF);
      rd(2'd1, v);        check("R7 mode ff", v, 8'hCA);
      wr(2'd1, 8'h00);
      check("R3 mode2 off", int'(mode2), 0);
      rdi(8'h5C, v);      check("R3 narrow index", v, 8'h8A);
      wr(2'd0, 8'h4C); wr(2'd1, 8'h40);
   endtask

   task automatic t_format;
      logic [7:0] v;
      wr(2'd0, 8'h48); wr(2'd1, 8'h5A);
      check("R5 strobe", int'(fmt_load), 1);
      check("R5 byte", fmt_byte, 8'h5A);
      @(negedge clk);
      check("R5 one cycle", int'(fmt_load), 0);
      wr(2'd0, 8'h08); wr(2'd1, 8'h37);
      check("R5 no strobe on drop", int'(fmt_load), 0);
      rd(2'd1, v);        check("R4 dropped", v, 8'h5A);
      wr(2'd0, 8'h18); wr(2'd1, 8'h10);
      wr(2'd0, 8'h08); wr(2'd1, 8'hC3);
      check("R5 partial strobe", int'(fmt_load), 1);
      rd(2'd1, v);        check("R4 partial", v, 8'hCA);
      wr(2'd0, 8'h18); wr(2'd1, 8'h00);
   endtask

   task automatic t_protect;
      logic [7:0] v;
      wr(2'd0, 8'h56); wr(2'd1, 8'hFF);
      rd(2'd1, v);        check("R6 reserved22", v, 8'h00);
      wr(2'd0, 8'h5D); wr(2'd1, 8'hFF);
      rd(2'd1, v);        check("R6 reserved29", v, 8'h00);
      wr(2'd0, 8'h49); wr(2'd1, 8'hFF);
      rd(2'd1, v);        check("R6 cfg bit5", v, 8'hDF);
      check("R6 play_en", int'(play_en), 1);
      wr(2'd3, 8'hFF);
      rd(2'd3, v);        check("R12 pio read", v, 8'h00);
      rdi(8'h49, v);      check("R12 pio no effect", v, 8'hDF);
   endtask

   task automatic t_irq;
      logic [7:0] v;
      wr(2'd0, 8'h58); wr(2'd1, 8'h60);
      @(negedge clk); play_irq_set = 1'b1;
      @(negedge clk); play_irq_set = 1'b0;
      check("R9 irq", int'(irq), 1);
      rd(2'd2, v);        check("R9 status", v, 8'h01);
      rd(2'd1, v);        check("R9 feat bit4", v, 8'h70);
      wr(2'd2, 8'h00);
      check("R8 irq drop", int'(irq), 0);
      rd(2'd1, v);        check("R8 feat cleared", v, 8'h00);
      @(negedge clk); play_irq_set = 1'b1;
      @(negedge clk); play_irq_set = 1'b0;
      wr(2'd1, 8'h10);
      check("R10 keep on 1to1", int'(irq), 1);
      wr(2'd1, 8'h00);
      check("R10 drop on fall", int'(irq), 0);
      @(negedge clk);
      bus_sel = 2'd2; bus_wr = 1'b1; play_irq_set = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; play_irq_set = 1'b0;
      check("R9 set wins", int'(irq), 1);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_cal;
      logic [7:0] v;
      wr(2'd0, 8'h4B); wr(2'd0, 8'h0B);
      rd(2'd1, v); rd(2'd1, v);
      wr(2'd0, 8'h4B);
      rd(2'd1, v);        check("R11 flag once", v, 8'h20);
      rd(2'd1, v);        check("R11 flag gone", v, 8'h00);
      wr(2'd0, 8'h49); wr(2'd1, 8'h00);
      check("R6 play_en off", int'(play_en), 0);
      wr(2'd0, 8'h0B); wr(2'd0, 8'h4B);
      rd(2'd1, v);        check("R11 not armed", v, 8'h00);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_checks++; n_errs++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_pointer_mode;
      t_format;
      t_protect;
      t_irq;
      t_cal;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule